// File: doc/BRIEF.md
# Dual-Output Clock Rate Divider

This block derives two slower timing streams from one master clock without creating any new clock nets. Each stream is a registered pair: a one-cycle tick that a consumer uses as a clock enable, and a level waveform that is high during the first part of every output period. The reference stream is either the master rate itself or the master rate divided by a power of two. The main stream is the master rate divided by a second, independent power-of-two prescaler. That prescaler is optionally followed by an integer divider whose ratio is the programmed code plus two.

All counting runs on the master clock. A new ratio is loaded only when the counter it governs wraps, so settings can be changed at any time while the block runs, without a reset and without runt pulses. A change of the divider bypass takes effect exactly at a main-period boundary.

Top module: `twin_rate_divider`

## Requirements
- R1: With `ref_use_pre` = 1, the reference period in master cycles is 1, 2, 4 or 8 for `ref_code` 00, 01, 10 or 11 respectively.
- R2: With `ref_use_pre` = 0, the reference path runs at the master rate: `ref_tick` is high in every cycle and `ref_wave` stays high.
- R3: With `div_bypass` = 0, the main period is P × (`div_code` + 2) master cycles. P is 1, 2, 4 or 8 for `main_code` 00, 01, 10 or 11. Code 0 gives a ratio of 2, and the all-ones 10-bit code gives 1025.
- R4: With `div_bypass` = 1, the main period is P master cycles, and `div_code` has no effect on it.
- R5: An output whose period is R units is high for max(1, floor(R/2)) units. For the main path with the divider in use, the high time is floor(D/2) × P master cycles, where D = `div_code` + 2.
- R6: Each tick is high for exactly one master cycle per output period. That cycle is the first cycle of the high phase.
- R7: A new code is loaded only when its own counter wraps. A reference code change, or a divide-code change, lets the period in progress finish at its old length. The following period then has the new length.
- R8: A change of `div_bypass` takes effect at the next main tick. The period in progress keeps its old length, and the period that starts at that tick has the new length.
- R9: While `rst_n` is low, both ticks and both waves are low. The master-clock edge after release starts a reference period, and the edge after that starts the first main period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_code | input | PRE_W | Reference prescaler code (power-of-two exponent) |
| main_code | input | PRE_W | Main prescaler code (power-of-two exponent) |
| div_code | input | DIV_W | Main divider code, ratio = code + 2 |
| div_bypass | input | 1 | 1 routes the main prescaler straight to the main output |
| ref_use_pre | input | 1 | 1 selects the reference prescaler, 0 selects the master rate |
| ref_tick | output | 1 | Reference clock-enable pulse, one per period |
| ref_wave | output | 1 | Reference output waveform |
| main_tick | output | 1 | Main clock-enable pulse, one per period |
| main_wave | output | 1 | Main output waveform |

## Verification
The main instance is built with a 4-bit divide code. This makes an exhaustive sweep of all four main prescaler codes against all sixteen divide ratios cheap, covering every odd and even high-phase split. A second instance keeps the default 10-bit code, so the extreme ratio of 1025 is reached, alone and behind the divide-by-8 prescaler (8200 cycles). Mid-period changes of the reference code, the divide code and the bypass bit confirm the boundary rules, and the reset window is checked cycle by cycle.

// File: rtl/twin_rate_pkg.sv
`timescale 1ns/1ps
package twin_rate_pkg;

   // One output stream: a single-cycle enable and the level waveform.
   typedef struct packed {
      logic tick;
      logic wave;
   } tr_phase_t;

endpackage

// File: rtl/tr_phase_ctr.sv
`timescale 1ns/1ps
module tr_phase_ctr
   import twin_rate_pkg::*;
#(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   input  logic          restart,
   input  logic [CW-1:0] ratio,
   output tr_phase_t     ph
);

   localparam logic [CW-1:0] ONE = CW'(1);

   if (CW < 2) begin : g_bad_cw
      $error("tr_phase_ctr: CW must be at least 2");
   end

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cur_q;
   logic [CW-1:0] hi_cur;
   logic          wrap;

   always_comb begin
      hi_cur = (cur_q <= ONE) ? ONE : (cur_q >> 1);
      wrap   = restart || (cnt_q == cur_q - ONE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         cur_q <= ONE;
         ph    <= '0;
      end else if (adv) begin
         if (wrap) begin
            cnt_q   <= '0;
            cur_q   <= (ratio == '0) ? ONE : ratio;
            ph.tick <= 1'b1;
            ph.wave <= 1'b1;
         end else begin
            cnt_q   <= cnt_q + ONE;
            ph.tick <= 1'b0;
            ph.wave <= (cnt_q + ONE) < hi_cur;
         end
      end else begin
         ph.tick <= 1'b0;
      end
   end

   // R7: the count never leaves the active ratio
   p_cnt_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < cur_q);

   // R7: the active ratio is replaced only at a wrap, marked by the tick
   p_reload_at_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cur_q) |-> ph.tick);

   // R6: a tick opens the high phase
   p_tick_opens_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ph.tick |-> ph.wave);

   // R6: a tick only follows an advance of the input stream
   p_tick_needs_adv_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ph.tick |-> $past(adv));

endmodule

// File: rtl/tr_prescaler.sv
`timescale 1ns/1ps
module tr_prescaler
   import twin_rate_pkg::*;
#(
   parameter int PRE_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PRE_W-1:0] code,
   input  logic             use_pre,
   output tr_phase_t        ph
);

   // Largest ratio is 2**(2**PRE_W - 1), which needs 2**PRE_W bits.
   localparam int CW = 1 << PRE_W;

   if (PRE_W < 1 || PRE_W > 3) begin : g_bad_pre
      $error("tr_prescaler: PRE_W must lie in 1..3");
   end

   logic [CW-1:0] ratio;

   always_comb begin
      ratio = use_pre ? (CW'(1) << code) : CW'(1);
   end

   tr_phase_ctr #(.CW(CW)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (1'b1),
      .restart (1'b0),
      .ratio   (ratio),
      .ph      (ph)
   );

endmodule

// File: rtl/tr_main_path.sv
`timescale 1ns/1ps
module tr_main_path
   import twin_rate_pkg::*;
#(
   parameter int PRE_W = 2,
   parameter int DIV_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PRE_W-1:0] code,
   input  logic [DIV_W-1:0] div_code,
   input  logic             bypass,
   output tr_phase_t        ph
);

   localparam int DCW = DIV_W + 1;

   if (DIV_W < 2 || DIV_W > 16) begin : g_bad_div
      $error("tr_main_path: DIV_W must lie in 2..16");
   end

   tr_phase_t      pre_ph;
   tr_phase_t      pre_d;
   tr_phase_t      div_ph;
   logic           byp_q;
   logic [DCW-1:0] div_ratio;

   always_comb begin
      div_ratio = {1'b0, div_code} + DCW'(2);
   end

   tr_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .code    (code),
      .use_pre (1'b1),
      .ph      (pre_ph)
   );

   // While bypassed the divider restarts on every prescaler tick, so both
   // sources sit at a period start whenever the selected one ticks.
   tr_phase_ctr #(.CW(DCW)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (pre_ph.tick),
      .restart (byp_q),
      .ratio   (div_ratio),
      .ph      (div_ph)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_d <= '0;
         byp_q <= 1'b0;
      end else begin
         pre_d <= pre_ph;
         if (ph.tick) byp_q <= bypass;
      end
   end

   assign ph = byp_q ? pre_d : div_ph;

   // R8: the source switches only right after a main tick
   p_switch_at_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(byp_q) |-> $past(ph.tick));

endmodule

// File: rtl/twin_rate_divider.sv
`timescale 1ns/1ps
module twin_rate_divider
   import twin_rate_pkg::*;
#(
   parameter int PRE_W = 2,
   parameter int DIV_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PRE_W-1:0] ref_code,
   input  logic [PRE_W-1:0] main_code,
   input  logic [DIV_W-1:0] div_code,
   input  logic             div_bypass,
   input  logic             ref_use_pre,
   output logic             ref_tick,
   output logic             ref_wave,
   output logic             main_tick,
   output logic             main_wave
);

   tr_phase_t ref_ph;
   tr_phase_t main_ph;

   // Selecting the master rate is a ratio of 1 loaded at the next wrap,
   // so the reference select needs no separate glitch-free mux.
   tr_prescaler #(.PRE_W(PRE_W)) u_ref (
      .clk     (clk),
      .rst_n   (rst_n),
      .code    (ref_code),
      .use_pre (ref_use_pre),
      .ph      (ref_ph)
   );

   tr_main_path #(.PRE_W(PRE_W), .DIV_W(DIV_W)) u_main (
      .clk      (clk),
      .rst_n    (rst_n),
      .code     (main_code),
      .div_code (div_code),
      .bypass   (div_bypass),
      .ph       (main_ph)
   );

   assign ref_tick  = ref_ph.tick;
   assign ref_wave  = ref_ph.wave;
   assign main_tick = main_ph.tick;
   assign main_wave = main_ph.wave;

endmodule

// File: tb/twin_rate_divider_test.sv
`timescale 1ns/1ps
module twin_rate_divider_test;

   localparam int PW  = 2;
   localparam int DW  = 4;
   localparam int DWF = 10;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic           rst_n;
   logic [PW-1:0]  rc, mc;
   logic [DW-1:0]  dc;
   logic [DWF-1:0] dcf;
   logic           byp, rsel;
   logic r_t, r_w, m_t, m_w, fr_t, fr_w, fm_t, fm_w;

   int checks = 0;
   int errors = 0;

   twin_rate_divider #(.PRE_W(PW), .DIV_W(DW)) uut (
      .clk(clk), .rst_n(rst_n), .ref_code(rc), .main_code(mc),
      .div_code(dc), .div_bypass(byp), .ref_use_pre(rsel),
      .ref_tick(r_t), .ref_wave(r_w), .main_tick(m_t), .main_wave(m_w)
   );

   twin_rate_divider #(.PRE_W(PW), .DIV_W(DWF)) uut_full (
      .clk(clk), .rst_n(rst_n), .ref_code(rc), .main_code(mc),
      .div_code(dcf), .div_bypass(byp), .ref_use_pre(rsel),
      .ref_tick(fr_t), .ref_wave(fr_w), .main_tick(fm_t), .main_wave(fm_w)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic tk(input int w);
      case (w)
         0: return r_t;
         1: return m_t;
         2: return fm_t;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic lv(input int w);
      case (w)
         0: return r_w;
         1: return m_w;
         2: return fm_w;
         default: return 1'b0;
      endcase
   endfunction

   function automatic int hi_of(input int r);
      return (r <= 1) ? 1 : r / 2;
   endfunction

   // Advance to the next tick of stream w (sampled at falling edges).
   task automatic sync(input int w);
      int n = 0;
      @(negedge clk);
      while (!tk(w) && n < 20000) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic settle(input int w);
      sync(w);
      sync(w);
   endtask

   task automatic measure(input int w, input int per_e, input int hi_e, input string req);
      int per = 0;
      int hi  = 0;
      sync(w);
      check(lv(w) == 1'b1, req, int'(lv(w)), 1);
      do begin
         if (lv(w)) hi++;
         per++;
         @(negedge clk);
      end while (!tk(w) && per < 20000);
      check(per == per_e, req, per, per_e);
      check(hi == hi_e, req, hi, hi_e);
   endtask

   initial begin
      #1900000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      rc = '0; mc = '0; dc = '0; dcf = '0; byp = 1'b0; rsel = 1'b0;

      // R9: quiet during reset, then the staged start
      repeat (3) @(negedge clk);
      check(!r_t && !r_w, "R9", int'({r_t, r_w}), 0);
      check(!m_t && !m_w, "R9", int'({m_t, m_w}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(r_t == 1'b1, "R9", int'(r_t), 1);
      check(m_t == 1'b0, "R9", int'(m_t), 0);
      @(negedge clk);
      check(m_t == 1'b1, "R9", int'(m_t), 1);

      // R2: master rate on the reference path
      settle(0);
      measure(0, 1, 1, "R2");
      measure(0, 1, 1, "R2");

      // R1: each reference prescaler code
      rsel = 1'b1;
      for (int c = 0; c < 4; c++) begin
         rc = PW'(c);
         settle(0);
         measure(0, 1 << c, hi_of(1 << c), "R1");
      end

      // R3 R5: exhaustive main sweep with the divider in use
      for (int p = 0; p < 4; p++) begin
         for (int d = 0; d < 16; d++) begin
            mc = PW'(p);
            dc = DW'(d);
            settle(1);
            measure(1, (1 << p) * (d + 2), ((d + 2) / 2) * (1 << p), "R3 R5");
         end
      end

      // R4: bypass ignores the divide code
      byp = 1'b1;
      for (int p = 0; p < 4; p++) begin
         mc = PW'(p);
         dc = DW'(0);
         settle(1);
         measure(1, 1 << p, hi_of(1 << p), "R4");
         dc = DW'(9);
         measure(1, 1 << p, hi_of(1 << p), "R4");
         dc = DW'(15);
         measure(1, 1 << p, hi_of(1 << p), "R4");
      end
      byp = 1'b0;

      // R7: reference code change in mid period
      begin
         int n;
         rc = 2'd3;
         settle(0);
         sync(0);
         repeat (2) @(negedge clk);
         rc = 2'd1;
         n = 2;
         while (!tk(0) && n < 20000) begin
            @(negedge clk);
            n++;
         end
         check(n == 8, "R7", n, 8);
         measure(0, 2, 1, "R7");
      end

      // R7: divide code change in mid period
      begin
         int n;
         mc = 2'd0;
         dc = DW'(9);
         settle(1);
         sync(1);
         repeat (3) @(negedge clk);
         dc = DW'(2);
         n = 3;
         while (!tk(1) && n < 20000) begin
            @(negedge clk);
            n++;
         end
         check(n == 11, "R7", n, 11);
         measure(1, 4, 2, "R7");
      end

      // R8: bypass switched on, then off, in mid period
      begin
         int n;
         mc = 2'd1;
         dc = DW'(3);
         settle(1);
         sync(1);
         repeat (3) @(negedge clk);
         byp = 1'b1;
         n = 3;
         while (!tk(1) && n < 20000) begin
            @(negedge clk);
            n++;
         end
         check(n == 10, "R8", n, 10);
         measure(1, 2, 1, "R8");
         sync(1);
         @(negedge clk);
         byp = 1'b0;
         n = 1;
         while (!tk(1) && n < 20000) begin
            @(negedge clk);
            n++;
         end
         check(n == 2, "R8", n, 2);
         measure(1, 10, 4, "R8");
      end

      // R3 R5: extreme ratios on the full-width divider
      mc = 2'd0;
      dcf = 10'd1023;
      settle(2);
      measure(2, 1025, 512, "R3 R5");
      mc = 2'd3;
      settle(2);
      measure(2, 8200, 4096, "R3 R5");
      mc = 2'd0;
      dcf = 10'd0;
      settle(2);
      measure(2, 2, 1, "R3 R5");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule